// File: doc/BRIEF.md
# Lockable Top-Region Write Filter

This block sits between a front end that has already decoded a two-wire serial memory bus into byte events and the write port of a 16,384-byte array. It follows each transaction through its selection byte, two address bytes and data bytes. For every data byte it issues a write qualifier together with the array address and the data. Inside a 64-byte page the address advances and wraps. The topmost 256 bytes of the array form a region that can be frozen. Until it is frozen, that region takes writes like any other location. A dedicated command transaction freezes it, and it then stays frozen until power is removed.

The frozen state stands in for a non-volatile bit. It is a register that only the power-on reset input clears, so a normal soft reset leaves it in place. A write-protect input overrides everything and blocks every write to the array. Software has no way to read the frozen state directly. It confirms the state by issuing the command and then reading the region back. The block reports the state on a status flag for the rest of the chip.

Top module: `lockable_wr_filter`

## Requirements
- R1: While either reset input is low, `wr_en_o` is 0. After power-on reset, `locked_o` is 0.
- R2: A write transaction is a start strobe followed by these byte events: a selection byte `{4'b1010, 1'b0, sel_i, 1'b0}`, a high address byte whose bits [5:0] give address bits [13:8], a low address byte, and then data bytes. One cycle after each data-byte event, `wr_en_o` is 1 for one cycle, with the current address on `wr_addr_o` and the byte on `wr_data_o`.
- R3: After each data byte, address bits [5:0] increment and wrap from 63 to 0. Bits [13:6] do not change.
- R4: While `locked_o` is 0, writes to addresses with bits [13:8] = 6'h3F are qualified exactly as writes elsewhere.
- R5: A transaction with selection byte 8'b1010_1100 and a first address byte whose bits [7:6] are 2'b11 sets `locked_o` at the clock edge that samples its stop strobe. Such a command transaction never asserts `wr_en_o`.
- R6: While locked, data bytes aimed at addresses with bits [13:8] = 6'h3F give `wr_en_o` = 0. Addresses below that region are still written.
- R7: A command transaction whose first address byte has bits [7:6] other than 2'b11 leaves `locked_o` unchanged. So does a command transaction cut short by a new start strobe before its stop.
- R8: While `wp_i` is 1, no data byte to any address asserts `wr_en_o`.
- R9: `locked_o` is never cleared by `rst_n` or by any transaction. Only `por_n` clears it, and after that the region takes writes again.
- R10: A selection byte with a different prefix, a different select field, bit 3 set (other than the command byte) or the read bit set makes the rest of the transaction produce no writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything including the lock |
| rst_n | input | 1 | Soft reset, active low, asynchronous; clears the sequencer only |
| sel_i | input | 2 | Strapped select value compared with selection-byte bits [2:1] |
| wp_i | input | 1 | Global write inhibit, 1 blocks all writes; tie low when unused |
| start_i | input | 1 | One-cycle strobe: start condition seen on the bus |
| stop_i | input | 1 | One-cycle strobe: stop condition seen on the bus |
| byte_vld_i | input | 1 | One-cycle strobe: a complete byte was received |
| byte_i | input | 8 | The received byte, valid with `byte_vld_i` |
| wr_en_o | output | 1 | Array write qualifier, one cycle per accepted data byte |
| wr_addr_o | output | 14 | Array address for the write |
| wr_data_o | output | 8 | Data for the write |
| locked_o | output | 1 | Top region frozen |

## Verification
The assertions take for granted that the strobes `start_i`, `stop_i` and `byte_vld_i` are mutually exclusive in any cycle and that each is a single-cycle pulse. They also assume that `wp_i` changes only between transactions. The region check relies on the lock never being set in the same cycle as a data write, and this holds because command transactions carry no data path. The stimulus drives exactly one strobe per event, with idle cycles between events, toggles `wp_i` only with the bus idle, and keeps the resets low across several clock edges.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  // Selection byte that marks the freeze command.
  localparam logic [7:0] LOCK_CMD_BYTE = 8'b1010_1100;
  // Fixed prefix of a memory selection byte.
  localparam logic [3:0] MEM_PREFIX    = 4'b1010;
  // Top two bits of the first address byte that arm the command.
  localparam logic [1:0] ARM_TAG       = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_DRAIN
  } seq_state_t;
endpackage

// File: rtl/lwf_rst_sync.sv
module lwf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  // Asserts at once, releases after STAGES clock edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lwf_parser.sv
module lwf_parser
  import lwf_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [1:0]        sel_i,
  output logic              fire_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o,
  output logic              lock_req_o
);
  localparam int HI_W = ADDR_W - 8;

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              cmd_q, cmd_d;
  logic              arm_q, arm_d;
  logic              fire;
  logic              dev_match;

  assign dev_match = (byte_i[7:4] == MEM_PREFIX) && !byte_i[3] &&
                     (byte_i[2:1] == sel_i) && !byte_i[0];

  // Next-state logic. Precedence: start, then stop, then byte.
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    cmd_d   = cmd_q;
    arm_d   = arm_q;
    fire    = 1'b0;
    if (start_i) begin
      state_d = ST_DEV;
      arm_d   = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      arm_d   = 1'b0;
    end else if (byte_vld_i) begin
      case (state_q)
        ST_DEV: begin
          if (byte_i == LOCK_CMD_BYTE) begin
            cmd_d   = 1'b1;
            state_d = ST_AHI;
          end else if (dev_match) begin
            cmd_d   = 1'b0;
            state_d = ST_AHI;
          end else begin
            state_d = ST_DRAIN;
          end
        end
        ST_AHI: begin
          if (cmd_q) begin
            arm_d   = (byte_i[7:6] == ARM_TAG);
            state_d = ST_DRAIN;
          end else begin
            addr_d[ADDR_W-1:8] = byte_i[HI_W-1:0];
            state_d            = ST_ALO;
          end
        end
        ST_ALO: begin
          addr_d[7:0] = byte_i;
          state_d     = ST_DATA;
        end
        ST_DATA: begin
          fire                = 1'b1;
          addr_d[PAGE_W-1:0]  = PAGE_W'(addr_q[PAGE_W-1:0] + 1'b1);
        end
        default: ;
      endcase
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cmd_q   <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      arm_q   <= arm_d;
      if (byte_vld_i) begin
        addr_q <= addr_d;
        cmd_q  <= cmd_d;
      end
    end
  end

  assign fire_o     = fire;
  assign addr_o     = addr_q;
  assign data_o     = byte_i;
  assign lock_req_o = stop_i & arm_q;
endmodule

// File: rtl/lwf_lock.sv
module lwf_lock (
  input  logic clk,
  input  logic por_rst_n,
  input  logic set_i,
  output logic locked_o
);
  logic lock_q, lock_d;

  // Sticky: there is no path back to 0 except power-on reset.
  always_comb lock_d = lock_q | set_i;

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) lock_q <= 1'b0;
    else if (set_i) lock_q <= lock_d;
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/lwf_gate.sv
module lwf_gate #(
  parameter int ADDR_W   = 14,
  parameter int REGION_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              wp_i,
  input  logic              locked_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  logic in_region;
  logic allow;
  logic en_d;
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  always_comb begin
    in_region = &addr_i[ADDR_W-1:REGION_W];
    allow     = !wp_i && (!in_region || !locked_i);
    en_d      = fire_i && allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      en_q <= en_d;
      if (fire_i) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign wr_en_o   = en_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/lockable_wr_filter.sv
module lockable_wr_filter #(
  parameter int ADDR_W      = 14,
  parameter int REGION_W    = 8,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [1:0]        sel_i,
  input  logic              wp_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              locked_o
);
  logic              por_s_n;
  logic              soft_s_n;
  logic              any_rst_n;
  logic              fire;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        cur_data;
  logic              lock_req;
  logic              locked;

  assign any_rst_n = por_n & rst_n;

  lwf_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_s_n)
  );

  lwf_rst_sync #(.STAGES(SYNC_STAGES)) u_soft_sync (
    .clk(clk), .arst_n(any_rst_n), .srst_n(soft_s_n)
  );

  lwf_parser #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_parser (
    .clk(clk), .rst_n(soft_s_n),
    .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .sel_i(sel_i),
    .fire_o(fire), .addr_o(cur_addr), .data_o(cur_data),
    .lock_req_o(lock_req)
  );

  lwf_lock u_lock (
    .clk(clk), .por_rst_n(por_s_n), .set_i(lock_req), .locked_o(locked)
  );

  lwf_gate #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_gate (
    .clk(clk), .rst_n(soft_s_n),
    .fire_i(fire), .addr_i(cur_addr), .data_i(cur_data),
    .wp_i(wp_i), .locked_i(locked),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  assign locked_o = locked;
endmodule

// File: rtl/lwf_checker.sv
module lwf_checker #(
  parameter int ADDR_W   = 14,
  parameter int REGION_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              wp_i,
  input logic              stop_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              locked_o
);
  localparam logic [ADDR_W-REGION_W-1:0] TOP_TAG = '1;

  // R1: soft reset held low keeps the write qualifier quiet.
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |-> !wr_en_o);

  // R5: the lock can only rise at an edge that sampled a stop strobe.
  p_lock_needs_stop_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(locked_o) |-> $past(stop_i));

  // R6: a write issued while locked never targets the top region.
  p_region_shut_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_en_o && $past(locked_o)) |-> (wr_addr_o[ADDR_W-1:REGION_W] != TOP_TAG));

  // R8: write protect inhibits the next qualifier.
  p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    wp_i |=> !wr_en_o);

  // R9: once set, the lock holds until power-on reset.
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    locked_o |=> locked_o);
endmodule

bind lockable_wr_filter lwf_checker #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wp_i(wp_i), .stop_i(stop_i),
  .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .locked_o(locked_o)
);

// File: tb/lockable_wr_filter_test.sv
module lockable_wr_filter_test;
  typedef struct {
    logic [13:0] addr;
    logic [7:0]  data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        por_n, rst_n, wp_i, start_i, stop_i, byte_vld_i;
  logic [1:0]  sel_i;
  logic [7:0]  byte_i;
  logic        wr_en_o, locked_o;
  logic [13:0] wr_addr_o;
  logic [7:0]  wr_data_o;

  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  exp_t q[$];
  exp_t got;

  always #10 clk = ~clk;  // 50 MHz

  lockable_wr_filter uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel_i(sel_i), .wp_i(wp_i),
    .start_i(start_i), .stop_i(stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .locked_o(locked_o)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected<100000", cyc);
      finish_run();
    end
  end

  // Monitor: every qualified write must match the head of the scoreboard.
  always @(negedge clk) begin
    if (wr_en_o === 1'b1) begin
      checks++;
      if (q.size() == 0) begin
        failures++;
        $display("FAIL R6/R8/R10/R5 unexpected write actual=%h:%h expected=none",
                 wr_addr_o, wr_data_o);
      end else begin
        got = q.pop_front();
        if (wr_addr_o !== got.addr || wr_data_o !== got.data) begin
          failures++;
          $display("FAIL %s write actual=%h:%h expected=%h:%h",
                   got.tag, wr_addr_o, wr_data_o, got.addr, got.data);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); byte_vld_i = 1'b1; byte_i = b;
    @(negedge clk); byte_vld_i = 1'b0;
    tick(1);
  endtask

  task automatic begin_txn();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic end_txn();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    tick(2);
  endtask

  // Full write transaction; pushes expected writes when ok is set.
  task automatic wr(input logic [7:0] dev, input logic [13:0] a, input int n,
                    input logic [7:0] seed, input bit ok, input string tag);
    exp_t e;
    begin_txn();
    put_byte(dev);
    put_byte({2'b00, a[13:8]});
    put_byte(a[7:0]);
    for (int i = 0; i < n; i++) begin
      if (ok) begin
        e.addr = {a[13:6], 6'(a[5:0] + 6'(i))};
        e.data = seed + 8'(i);
        e.tag  = tag;
        q.push_back(e);
      end
      put_byte(seed + 8'(i));
    end
    end_txn();
  endtask

  localparam logic [7:0] DEV_OK   = 8'hA2;  // prefix 1010, sel=01, write
  localparam logic [7:0] LOCK_CMD = 8'hAC;

  initial begin
    por_n = 1'b0; rst_n = 1'b0; wp_i = 1'b0; sel_i = 2'b01;
    start_i = 1'b0; stop_i = 1'b0; byte_vld_i = 1'b0; byte_i = 8'h00;
    tick(3);
    check(wr_en_o === 1'b0, "R1 wr_en in reset", int'(wr_en_o), 0);
    por_n = 1'b1; rst_n = 1'b1;
    tick(4);
    check(locked_o === 1'b0, "R1 lock after power-on", int'(locked_o), 0);
    check(wr_en_o === 1'b0, "R1 wr_en after reset", int'(wr_en_o), 0);

    // R2 plain write, two bytes
    wr(DEV_OK, 14'h0123, 2, 8'hA5, 1'b1, "R2");
    // R3 page wrap 0x023E -> 0x023F -> 0x0200
    wr(DEV_OK, 14'h023E, 3, 8'h40, 1'b1, "R3");
    // R4 region writable while unlocked, including a wrap inside it
    wr(DEV_OK, 14'h3F10, 1, 8'h11, 1'b1, "R4");
    wr(DEV_OK, 14'h3FFF, 2, 8'h70, 1'b1, "R4");

    // R10 non-matching selection bytes
    wr(8'hA4, 14'h0050, 2, 8'h21, 1'b0, "R10");
    wr(8'hA3, 14'h0050, 2, 8'h22, 1'b0, "R10");
    wr(8'hB2, 14'h0050, 2, 8'h23, 1'b0, "R10");
    wr(8'hAA, 14'h0050, 2, 8'h24, 1'b0, "R10");

    // R7 command with wrong tag bits
    begin_txn(); put_byte(LOCK_CMD); put_byte(8'h80); put_byte(8'h00); end_txn();
    check(locked_o === 1'b0, "R7 wrong tag", int'(locked_o), 0);
    // R7 command cut short by a new start
    begin_txn(); put_byte(LOCK_CMD); put_byte(8'hC0);
    begin_txn(); end_txn();
    check(locked_o === 1'b0, "R7 aborted command", int'(locked_o), 0);

    // R8 write protect blocks everywhere
    wp_i = 1'b1;
    wr(DEV_OK, 14'h0010, 2, 8'h31, 1'b0, "R8");
    wr(DEV_OK, 14'h3F20, 1, 8'h32, 1'b0, "R8");
    wp_i = 1'b0;
    tick(2);

    // R5 freeze command; its data bytes must not write
    begin_txn(); put_byte(LOCK_CMD); put_byte(8'hC0); put_byte(8'h00);
    put_byte(8'h12); put_byte(8'h34);
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    check(locked_o === 1'b1, "R5 lock after stop", int'(locked_o), 1);
    tick(2);

    // R6 region blocked, neighbour still writable
    wr(DEV_OK, 14'h3F20, 2, 8'h51, 1'b0, "R6");
    wr(DEV_OK, 14'h3EFF, 2, 8'h61, 1'b1, "R6");
    // R6 repeating the command keeps it locked
    begin_txn(); put_byte(LOCK_CMD); put_byte(8'hC0); end_txn();
    check(locked_o === 1'b1, "R6 still locked", int'(locked_o), 1);

    // R9 soft reset leaves the lock alone
    @(negedge clk); rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check(locked_o === 1'b1, "R9 lock after soft reset", int'(locked_o), 1);
    wr(DEV_OK, 14'h3F00, 1, 8'h71, 1'b0, "R9");

    // R9 power-on reset clears it and the region opens again
    @(negedge clk); por_n = 1'b0;
    tick(3);
    por_n = 1'b1;
    tick(4);
    check(locked_o === 1'b0, "R9 lock after power-on", int'(locked_o), 0);
    wr(DEV_OK, 14'h3F00, 1, 8'h81, 1'b1, "R9");

    tick(5);
    check(q.size() == 0, "R2 pending expected writes", q.size(), 0);
    finish_run();
  end
endmodule